// File: doc/BRIEF.md
# Power-Stage Fault Protection Sequencer

This block makes the start-up and fault decisions for a boost converter that sits behind an external isolation switch. Five digital flags come from analog comparators outside the block:
- input above the undervoltage threshold
- enable
- output overvoltage
- feedback below 90% of nominal
- supply rail has risen

Each flag passes through a synchronizer. A finite state machine then drives three outputs:
- an active-low request for the isolation gate
- an enable for the power switch
- a latched-fault flag

A three-bit status word shows the current state.

Time is counted in millisecond ticks. A prescaler divides the clock by `TICK_DIV` to make the ticks, and a short divider makes a simulation run quickly. At power-up the block closes the isolation switch. After a fixed check window it verifies the rail and the feedback. On a failure it opens the switch for an off-time and retries. After a set number of failures it shuts down for good, and only a drop and return of the input supply clears that shutdown. Feedback that stays low for a long window while running also causes the shutdown. The overvoltage comparator only blanks switching while it is tripped.

Top module: `pwr_fault_seq`

## Requirements
- R1: After reset the status is 0 (off), `gate_n` is 1, `sw_en` is 0 and `fault_latched` is 0.
- R2: `gate_n` is 0 only in the checking or running state. These states are entered only while both the undervoltage-ok flag and enable are high. Enable going low in either state returns the block to off, with `gate_n` at 1.
- R3: A low undervoltage-ok flag forces the off state from any state, including the latched state. All outputs then take their off values.
- R4: In the checking state the flags are judged `CHECK_MS` ticks after entry. If the rail has risen and feedback is not low, the block goes to running. If the rail has not risen or feedback is low, the check fails.
- R5: A failed check, when it is not the last allowed one, enters retry-wait with `gate_n` at 1 for `OFF_MS` ticks. After that the block re-enters checking if undervoltage-ok and enable are both high, and goes to off otherwise.
- R6: The failure that brings the failure count to `MAX_TRIES` enters the latched state: `gate_n` is 1, `sw_en` is 0 and `fault_latched` is 1. Toggling enable does not leave this state.
- R7: Only a low and then high undervoltage-ok flag leaves the latched state. This also sets the failure count to zero, so the next start-up reaches running.
- R8: While running, a rail-risen flag going low counts as a failure and follows the same retry or latch path as a failed check.
- R9: `sw_en` is 1 in the checking and running states whenever the overvoltage flag is low. It is 0 while the overvoltage flag is high and returns to 1 when the flag clears. The state does not change because of the overvoltage flag.
- R10: While running, feedback that stays low without a break for `FBLOW_MS` ticks enters the latched state. A shorter low period has no effect on the state.
- R11: The failure count returns to zero after `OFF_MS` ticks of running with the rail up and feedback not low. Until that window completes, earlier failures still count.
- R12: The status encoding is 0 for off, 1 for checking, 2 for running, 3 for retry-wait and 4 for latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| uv_ok_a | input | 1 | Input above undervoltage threshold (asynchronous) |
| en_a | input | 1 | Enable (asynchronous) |
| ovp_a | input | 1 | Output overvoltage comparator tripped (asynchronous) |
| fb_low_a | input | 1 | Feedback below 90% of nominal (asynchronous) |
| sup_up_a | input | 1 | Supply rail has risen (asynchronous) |
| gate_n | output | 1 | Isolation switch request, 0 closes the switch |
| sw_en | output | 1 | Power switch may be switched |
| fault_latched | output | 1 | Shutdown latched until input power cycle |
| status | output | 3 | State code per R12 |

## Verification
The hardest situation to reach is the boundary of the failure-count clearing window. Failures must accumulate across a start-up that passes, and the rail must then drop either before or after a full window of clean running. The stimulus builds up two failures by holding the rail low through a retry. It releases the rail during the second off-time and drops it again at once in one run, and only after waiting past the window in another run. The outcome, latched or retry, tells whether the count was kept or cleared. Random runs vary the number of failures before a good start and the cause of each failure, and toggle the overvoltage flag with random hold times while running.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_CHECK = 3'd1,
      ST_RUN   = 3'd2,
      ST_RETRY = 3'd3,
      ST_LATCH = 3'd4
   } pfs_state_e;

   typedef struct packed {
      logic uv_ok;
      logic en;
      logic ovp;
      logic fb_low;
      logic sup_up;
   } pfs_flags_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pfs_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pfs_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pfs_tick.sv
module pfs_tick #(
   parameter int DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("pfs_tick: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
   import pfs_pkg::*;
#(
   parameter int CHECK_MS  = 2,
   parameter int OFF_MS    = 55,
   parameter int FBLOW_MS  = 55,
   parameter int MAX_TRIES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  pfs_flags_t f,
   output logic       tmr_clr,
   output logic       gate_n,
   output logic       sw_en,
   output logic       fault_latched,
   output logic [2:0] status
);

   localparam int TMAX = (OFF_MS > FBLOW_MS) ?
                         ((OFF_MS > CHECK_MS) ? OFF_MS : CHECK_MS) :
                         ((FBLOW_MS > CHECK_MS) ? FBLOW_MS : CHECK_MS);
   localparam int TW = $clog2(TMAX + 1);
   localparam int NW = $clog2(MAX_TRIES + 1);
   localparam logic [TW-1:0] CHK_LAST = TW'(CHECK_MS - 1);
   localparam logic [TW-1:0] OFF_LAST = TW'(OFF_MS - 1);
   localparam logic [TW-1:0] FBL_LAST = TW'(FBLOW_MS - 1);
   localparam logic [NW-1:0] TRY_LIM  = NW'(MAX_TRIES);

   if (CHECK_MS < 1 || OFF_MS < 1 || FBLOW_MS < 1) begin : g_bad_ms
      $error("pfs_fsm: millisecond windows must be at least 1");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("pfs_fsm: MAX_TRIES must be at least 1");
   end

   pfs_state_e    state_q, state_d;
   logic [TW-1:0] phase_q, fbl_q, good_q;
   logic [NW-1:0] tries_q, tries_inc;
   logic          go, chk_done, off_done, fbl_expire, clean, good_done;
   logic          chk_bad, sc_fail, last_try, on_st;

   assign go         = f.uv_ok && f.en;
   assign chk_done   = tick && (phase_q == CHK_LAST);
   assign off_done   = tick && (phase_q == OFF_LAST);
   assign fbl_expire = tick && f.fb_low && (fbl_q == FBL_LAST);
   assign clean      = f.sup_up && !f.fb_low;
   assign good_done  = tick && clean && (good_q == OFF_LAST) && (state_q == ST_RUN);
   assign chk_bad    = !f.sup_up || f.fb_low;
   assign tries_inc  = tries_q + 1'b1;
   assign last_try   = (tries_inc >= TRY_LIM);

   always_comb begin
      state_d = state_q;
      sc_fail = 1'b0;
      case (state_q)
         ST_OFF:   if (go) state_d = ST_CHECK;
         ST_CHECK: begin
            if (!f.en) state_d = ST_OFF;
            else if (chk_done) begin
               if (chk_bad) begin
                  sc_fail = 1'b1;
                  state_d = last_try ? ST_LATCH : ST_RETRY;
               end else begin
                  state_d = ST_RUN;
               end
            end
         end
         ST_RUN: begin
            if (!f.en) state_d = ST_OFF;
            else if (!f.sup_up) begin
               sc_fail = 1'b1;
               state_d = last_try ? ST_LATCH : ST_RETRY;
            end else if (fbl_expire) begin
               state_d = ST_LATCH;
            end
         end
         ST_RETRY: if (off_done) state_d = go ? ST_CHECK : ST_OFF;
         ST_LATCH: state_d = ST_LATCH;
         default:  state_d = ST_OFF;
      endcase
      if (!f.uv_ok) begin
         state_d = ST_OFF;
         sc_fail = 1'b0;
      end
   end

   assign tmr_clr = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (tmr_clr) phase_q <= '0;
      else if (tick && (state_q == ST_CHECK || state_q == ST_RETRY))
         phase_q <= phase_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fbl_q <= '0;
      else if (state_q != ST_RUN || !f.fb_low || tmr_clr) fbl_q <= '0;
      else if (tick && fbl_q != FBL_LAST) fbl_q <= fbl_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) good_q <= '0;
      else if (state_q != ST_RUN || !clean || tmr_clr) good_q <= '0;
      else if (tick && good_q != OFF_LAST) good_q <= good_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tries_q <= '0;
      else if (!f.uv_ok)  tries_q <= '0;
      else if (sc_fail)   tries_q <= last_try ? TRY_LIM : tries_inc;
      else if (good_done) tries_q <= '0;
   end

   assign on_st         = (state_q == ST_CHECK) || (state_q == ST_RUN);
   assign gate_n        = !on_st;
   assign sw_en         = on_st && !f.ovp;
   assign fault_latched = (state_q == ST_LATCH);
   assign status        = state_q;

   p_gate_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_n |-> $past(f.uv_ok && f.en));

   p_uv_forces_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!f.uv_ok) |-> state_q == ST_OFF);

   p_retry_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_RETRY) |-> ($past(state_q) == ST_CHECK || $past(state_q) == ST_RUN));

   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCH && f.uv_ok) |=> state_q == ST_LATCH);

   p_sw_needs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en |-> !gate_n);

   p_ovp_keeps_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && f.ovp && go && clean) |=> state_q == ST_RUN);

   p_latch_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_LATCH) |-> ($past(state_q) == ST_CHECK || $past(state_q) == ST_RUN));

   p_tries_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_LATCH) |-> tries_q < TRY_LIM);

endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
   import pfs_pkg::*;
#(
   parameter int TICK_DIV    = 50000,
   parameter int CHECK_MS    = 2,
   parameter int OFF_MS      = 55,
   parameter int FBLOW_MS    = 55,
   parameter int MAX_TRIES   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uv_ok_a,
   input  logic       en_a,
   input  logic       ovp_a,
   input  logic       fb_low_a,
   input  logic       sup_up_a,
   output logic       gate_n,
   output logic       sw_en,
   output logic       fault_latched,
   output logic [2:0] status
);

   localparam int FW = $bits(pfs_flags_t);

   pfs_flags_t raw, syn;
   logic [FW-1:0] syn_v;
   logic tick, tmr_clr;

   assign raw = '{uv_ok: uv_ok_a, en: en_a, ovp: ovp_a, fb_low: fb_low_a, sup_up: sup_up_a};

   pfs_sync #(.WIDTH(FW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn_v)
   );
   assign syn = pfs_flags_t'(syn_v);

   pfs_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
   );

   pfs_fsm #(
      .CHECK_MS(CHECK_MS), .OFF_MS(OFF_MS),
      .FBLOW_MS(FBLOW_MS), .MAX_TRIES(MAX_TRIES)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .f(syn),
      .tmr_clr(tmr_clr), .gate_n(gate_n), .sw_en(sw_en),
      .fault_latched(fault_latched), .status(status)
   );

endmodule

// File: tb/pwr_fault_seq_tb.sv
module pwr_fault_seq_tb;

   localparam int DIV = 4;
   localparam int CHK = 2;
   localparam int OFF = 55;
   localparam int FBL = 55;
   localparam int CHK_CYC = CHK * DIV;
   localparam int OFF_CYC = OFF * DIV;
   localparam int FBL_CYC = FBL * DIV;

   localparam logic [2:0] S_OFF = 3'd0, S_CHECK = 3'd1, S_RUN = 3'd2,
                          S_RETRY = 3'd3, S_LATCH = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv = 1'b0, en = 1'b0, ovp = 1'b0, fbl = 1'b0, sup = 1'b0;
   logic gate_n, sw_en, fault_latched;
   logic [2:0] status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_fault_seq #(
      .TICK_DIV(DIV), .CHECK_MS(CHK), .OFF_MS(OFF),
      .FBLOW_MS(FBL), .MAX_TRIES(3), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .uv_ok_a(uv), .en_a(en), .ovp_a(ovp),
      .fb_low_a(fbl), .sup_up_a(sup), .gate_n(gate_n), .sw_en(sw_en),
      .fault_latched(fault_latched), .status(status)
   );

   function automatic logic exp_sw(input logic [2:0] st, input logic ov);
      return (st == S_CHECK || st == S_RUN) && !ov;
   endfunction

   function automatic logic exp_gate_n(input logic [2:0] st);
      return !(st == S_CHECK || st == S_RUN);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_for(input logic [2:0] tgt, input int maxc, output int n);
      n = 0;
      while (status != tgt && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic power_cycle();
      uv = 1'b0;
      cyc(6);
      check(status == S_OFF, "R3 off after uv low", status, S_OFF);
      check(fault_latched == 1'b0, "R7 latch cleared", fault_latched, 0);
      uv = 1'b1;
   endtask

   initial begin
      int n;
      int k;
      void'($urandom(32'd20240611));
      cyc(3);
      check(status == S_OFF, "R1 status", status, S_OFF);
      check(gate_n == 1'b1 && sw_en == 1'b0 && fault_latched == 1'b0, "R1 outputs",
            {gate_n, sw_en, fault_latched}, 3'b100);
      rst_n = 1'b1;
      cyc(2);

      // R2: uv ok but enable low keeps gate open
      uv = 1'b1; sup = 1'b1;
      cyc(10);
      check(status == S_OFF && gate_n == 1'b1, "R2 no enable", status, S_OFF);

      // R2/R4/R12: start-up with good flags
      en = 1'b1;
      wait_for(S_CHECK, 10, n);
      check(status == S_CHECK, "R12 checking code", status, S_CHECK);
      check(gate_n == 1'b0, "R2 gate closed", gate_n, 0);
      wait_for(S_RUN, 30, n);
      check(status == S_RUN, "R4 pass to running", status, S_RUN);
      check(n >= CHK_CYC - 2 && n <= CHK_CYC + 2, "R4 check window", n, CHK_CYC);
      check(sw_en == 1'b1, "R9 switching on", sw_en, 1);

      // R9: random overvoltage toggles while running
      for (int i = 0; i < 8; i++) begin
         ovp = $urandom_range(0, 1);
         cyc($urandom_range(4, 12));
         check(sw_en == exp_sw(status, ovp), "R9 ovp blanking", sw_en, exp_sw(status, ovp));
         check(status == S_RUN, "R9 state kept", status, S_RUN);
      end
      ovp = 1'b0;

      // R2: enable low returns to off, high restarts
      en = 1'b0;
      cyc(5);
      check(status == S_OFF && gate_n == 1'b1, "R2 enable drop", status, S_OFF);
      en = 1'b1;
      wait_for(S_RUN, 40, n);
      check(status == S_RUN, "R2 restart", status, S_RUN);

      // R8/R5/R6: rail loss while running, two retries then latch
      sup = 1'b0;
      wait_for(S_RETRY, 8, n);
      check(status == S_RETRY, "R8 rail loss fails", status, S_RETRY);
      check(gate_n == exp_gate_n(status) && sw_en == 1'b0, "R5 gate open in retry", gate_n, 1);
      wait_for(S_CHECK, OFF_CYC + 20, n);
      check(n >= OFF_CYC - 4 && n <= OFF_CYC + 4, "R5 off-time", n, OFF_CYC);
      wait_for(S_RETRY, 30, n);
      check(status == S_RETRY, "R4 rail low fails check", status, S_RETRY);
      wait_for(S_CHECK, OFF_CYC + 20, n);
      wait_for(S_LATCH, 30, n);
      check(status == S_LATCH, "R6 third failure latches", status, S_LATCH);
      check(fault_latched == 1'b1 && gate_n == 1'b1 && sw_en == 1'b0, "R6 latched outputs",
            {fault_latched, gate_n, sw_en}, 3'b110);
      sup = 1'b1;
      en = 1'b0; cyc(8); en = 1'b1; cyc(8);
      check(status == S_LATCH, "R6 enable toggle ignored", status, S_LATCH);

      // R7/R3: power cycle clears latch
      power_cycle();
      wait_for(S_RUN, 40, n);
      check(status == S_RUN, "R7 restart after power cycle", status, S_RUN);

      // R11 contrast: two failures, pass, immediate loss latches
      sup = 1'b0;
      wait_for(S_RETRY, 8, n);
      wait_for(S_CHECK, OFF_CYC + 20, n);
      wait_for(S_RETRY, 30, n);
      sup = 1'b1;
      wait_for(S_RUN, OFF_CYC + 40, n);
      check(status == S_RUN, "R11 pass after two fails", status, S_RUN);
      cyc(20);
      sup = 1'b0;
      cyc(6);
      check(status == S_LATCH, "R11 count kept before window", status, S_LATCH);
      sup = 1'b1;
      power_cycle();
      wait_for(S_RUN, 40, n);

      // R11: same, but wait past the clean window first
      sup = 1'b0;
      wait_for(S_RETRY, 8, n);
      wait_for(S_CHECK, OFF_CYC + 20, n);
      wait_for(S_RETRY, 30, n);
      sup = 1'b1;
      wait_for(S_RUN, OFF_CYC + 40, n);
      cyc(OFF_CYC + 30);
      sup = 1'b0;
      cyc(6);
      check(status == S_RETRY, "R11 count cleared after window", status, S_RETRY);
      sup = 1'b1;
      wait_for(S_RUN, OFF_CYC + 40, n);

      // R10: short low feedback ignored, long one latches
      fbl = 1'b1;
      cyc(FBL_CYC / 2);
      fbl = 1'b0;
      cyc(10);
      check(status == S_RUN, "R10 short low ignored", status, S_RUN);
      fbl = 1'b1;
      wait_for(S_LATCH, FBL_CYC + 40, n);
      check(status == S_LATCH, "R10 persistent low latches", status, S_LATCH);
      check(n >= FBL_CYC - 8 && n <= FBL_CYC + 12, "R10 window length", n, FBL_CYC);
      fbl = 1'b0;

      // R3: uv drop while running
      power_cycle();
      wait_for(S_RUN, 40, n);
      uv = 1'b0;
      cyc(5);
      check(status == S_OFF && gate_n == 1'b1 && sw_en == 1'b0, "R3 uv drop from run",
            status, S_OFF);

      // Random: 0..2 failures of random cause, then a good start
      for (int it = 0; it < 6; it++) begin
         k = $urandom_range(0, 2);
         if (k > 0) begin
            if ($urandom_range(0, 1) == 0) sup = 1'b0; else fbl = 1'b1;
         end
         uv = 1'b1;
         for (int j = 0; j < k; j++) begin
            wait_for(S_RETRY, 40, n);
            check(status == S_RETRY, "R4 random failed check", status, S_RETRY);
            if (j == k - 1) begin sup = 1'b1; fbl = 1'b0; end
            wait_for(S_CHECK, OFF_CYC + 20, n);
         end
         wait_for(S_RUN, 40, n);
         check(status == S_RUN, "R5 random retry recovers", status, S_RUN);
         uv = 1'b0;
         cyc(6);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule